// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope integrating converter with a three-and-a-half digit decimal result. A free-running prescaler turns the master clock into a count strobe. On each strobe the sequencer advances through a fixed loop of three phases: zeroing, integration of the unknown input, and de-integration against a reference. It drives one select line per phase to the analog switches. During de-integration it picks which reference sign to apply. It watches a single comparator bit to learn the input sign and the moment of the zero crossing.

The de-integration time is counted in a chain of decimal digits. The finished count and the sign are captured into a held result. The last three digits are full decimal digits and the leading digit is only 0 or 1. Any de-integration time that goes unused is added to the next zeroing phase, so every conversion takes the same number of clocks. A lamp-test input overrides the shown value with every segment lit. It leaves the captured result and the timing untouched.

Top module: `dsq_sequencer`

## Requirements
- R1: One count lasts exactly CLK_DIV clock cycles (default 4). Every phase change falls on a count boundary, so each phase length is a whole multiple of CLK_DIV clocks.
- R2: The integrate phase (`ph_si` high) lasts exactly SI_COUNTS counts (default 1000).
- R3: De-integration (`ref_pos` or `ref_neg` high) ends on the first count at which `cmp_i` differs from the sign latched for this conversion. If that happens on the n-th count, de-integration has lasted n counts.
- R4: The zeroing phase after a de-integration of n counts lasts CYCLE_COUNTS − SI_COUNTS − n counts. The start of one integrate phase and the start of the next are therefore always CYCLE_COUNTS × CLK_DIV clocks apart.
- R5: Exactly one of `ph_az`, `ph_si`, `ref_pos`, `ref_neg` is high at any time. The phases run zeroing, then integrate, then de-integration, then back to zeroing.
- R6: `cmp_i` is sampled on the last count of the integrate phase; 1 means a negative input. During de-integration `ref_pos` is high for a negative input and `ref_neg` for a positive one. After the conversion, `disp_sign` shows the sampled value.
- R7: If the REF_MAX-th count (default 2000) of de-integration is reached, de-integration stops there and `disp_ovr` is set. The shown result is then `disp_msd`=1 with `disp_d2`, `disp_d1` and `disp_d0` all equal to 4'hF (blank).
- R8: The shown sign, digits and overrange flag change only in the clock cycle that ends de-integration.
- R9: While `test_all` is high, `disp_sign`=1, `disp_msd`=1 and `disp_d2`, `disp_d1`, `disp_d0` each read 4'h8, and `disp_ovr` keeps its held value. Phase timing and result capture go on unchanged underneath.
- R10: Synchronous reset puts the block in zeroing with all display outputs 0. The first zeroing phase after reset lasts CYCLE_COUNTS − SI_COUNTS − REF_MAX counts.
- R11: For an in-range result of n counts, the display shows n in decimal. `disp_msd` is the thousands digit (0 or 1), and `disp_d2`, `disp_d1` and `disp_d0` are the hundreds, tens and units in BCD (4'h0 to 4'h9), with carries between digits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_i | input | 1 | Comparator bit, already synchronous to clk; 1 = integrator indicates negative input |
| test_all | input | 1 | Lamp test: light every display segment |
| ph_az | output | 1 | Zeroing phase select |
| ph_si | output | 1 | Input-integrate phase select |
| ref_pos | output | 1 | De-integrate with positive reference |
| ref_neg | output | 1 | De-integrate with negative reference |
| disp_sign | output | 1 | Minus sign of the shown result |
| disp_msd | output | 1 | Leading half digit (0 or 1) |
| disp_d2 | output | 4 | Hundreds digit, BCD (4'hF = blank) |
| disp_d1 | output | 4 | Tens digit, BCD (4'hF = blank) |
| disp_d0 | output | 4 | Units digit, BCD (4'hF = blank) |
| disp_ovr | output | 1 | Last conversion hit the de-integration limit |

## Verification
A wrong phase counter or a wrong stored zeroing length shows up at the phase select outputs within one conversion: a phase that is too long or too short by a single count moves a select edge by CLK_DIV clocks. A wrong decimal carry or a wrong sign capture stays hidden until the end of de-integration. It then appears in the held digits, because the result is latched in that cycle. The bench measures every phase length in clocks. It checks the captured value against decimal values worked out from the de-integration length it chose, including counts that roll one, two and three digits at once, and the overrange limit.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

    // Three full decimal digits plus the leading digit in the counter chain.
    localparam int NDIG = 4;

    localparam logic [3:0] DIG_BLANK = 4'hF;
    localparam logic [3:0] DIG_LAMP  = 4'h8;

    typedef logic [3:0] bcd_t;

    typedef enum logic [1:0] {
        PH_AZ = 2'd0,
        PH_SI = 2'd1,
        PH_RI = 2'd2
    } phase_e;

    typedef struct packed {
        logic neg;
        logic ovr;
        logic msd;
        bcd_t hun;
        bcd_t ten;
        bcd_t one;
    } disp_t;

    // Advance one decimal digit, wrapping 9 back to 0.
    function automatic bcd_t bcd_step(input bcd_t d);
        return (d == 4'd9) ? 4'd0 : d + 4'd1;
    endfunction

    // Value shown while the lamp test is active; overrange flag passes through.
    function automatic disp_t lamp_value(input logic ovr_held);
        disp_t v;
        v.neg = 1'b1;
        v.ovr = ovr_held;
        v.msd = 1'b1;
        v.hun = DIG_LAMP;
        v.ten = DIG_LAMP;
        v.one = DIG_LAMP;
        return v;
    endfunction

endpackage

// File: rtl/dsq_prescale.sv
module dsq_prescale #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + W'(1);
        end
    end

    assign tick = (div_q == LAST);

endmodule

// File: rtl/dsq_bcd_chain.sv
module dsq_bcd_chain
    import dsq_pkg::*;
#(
    parameter int DIGITS = NDIG
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    adv,
    output logic [DIGITS-1:0][3:0]  q_next
);
    logic [DIGITS-1:0][3:0] q;
    logic [DIGITS-1:0]      carry;

    assign carry[0] = 1'b1;

    generate
        for (genvar i = 0; i < DIGITS; i++) begin : g_dig
            assign q_next[i] = carry[i] ? bcd_step(q[i]) : q[i];
            if (i < DIGITS - 1) begin : g_carry
                assign carry[i+1] = carry[i] & (q[i] == 4'd9);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else if (adv) begin
            q <= q_next;
        end
    end

endmodule

// File: rtl/dsq_phase_fsm.sv
module dsq_phase_fsm
    import dsq_pkg::*;
#(
    parameter int SI_COUNTS    = 1000,
    parameter int REF_MAX      = 2000,
    parameter int CYCLE_COUNTS = 4000
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   cmp_i,
    output phase_e phase,
    output logic   pol,
    output logic   clr_cnt,
    output logic   adv_cnt,
    output logic   done,
    output logic   done_ovr
);
    localparam int CNT_W = $clog2(CYCLE_COUNTS + 1);
    localparam logic [CNT_W-1:0] SI_LAST  = CNT_W'(SI_COUNTS - 1);
    localparam logic [CNT_W-1:0] REF_LAST = CNT_W'(REF_MAX - 1);
    localparam logic [CNT_W-1:0] AZ_SPAN  = CNT_W'(CYCLE_COUNTS - SI_COUNTS);
    localparam logic [CNT_W-1:0] AZ_MIN   = CNT_W'(CYCLE_COUNTS - SI_COUNTS - REF_MAX);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] az_len;
    logic             crossed;
    logic             last_ri;

    assign crossed  = cmp_i ^ pol;
    assign last_ri  = (cnt == REF_LAST);

    assign clr_cnt  = tick && (phase == PH_SI) && (cnt == SI_LAST);
    assign adv_cnt  = tick && (phase == PH_RI);
    assign done     = adv_cnt && (crossed || last_ri);
    assign done_ovr = last_ri;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_AZ;
            cnt    <= '0;
            az_len <= AZ_MIN;
            pol    <= 1'b0;
        end else if (tick) begin
            case (phase)
                PH_AZ: begin
                    if (cnt == az_len - CNT_W'(1)) begin
                        phase <= PH_SI;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                PH_SI: begin
                    if (cnt == SI_LAST) begin
                        phase <= PH_RI;
                        cnt   <= '0;
                        pol   <= cmp_i;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                PH_RI: begin
                    if (crossed || last_ri) begin
                        phase  <= PH_AZ;
                        cnt    <= '0;
                        az_len <= AZ_SPAN - (cnt + CNT_W'(1));
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: begin
                    phase <= PH_AZ;
                    cnt   <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/dsq_sequencer.sv
module dsq_sequencer
    import dsq_pkg::*;
#(
    parameter int CLK_DIV      = 4,
    parameter int SI_COUNTS    = 1000,
    parameter int REF_MAX      = 2000,
    parameter int CYCLE_COUNTS = 4000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmp_i,
    input  logic       test_all,
    output logic       ph_az,
    output logic       ph_si,
    output logic       ref_pos,
    output logic       ref_neg,
    output logic       disp_sign,
    output logic       disp_msd,
    output logic [3:0] disp_d2,
    output logic [3:0] disp_d1,
    output logic [3:0] disp_d0,
    output logic       disp_ovr
);
    logic                  tick;
    phase_e                phase;
    logic                  pol;
    logic                  clr_cnt;
    logic                  adv_cnt;
    logic                  done;
    logic                  done_ovr;
    logic [NDIG-1:0][3:0]  cnt_next;
    disp_t                 held;
    disp_t                 shown;

    dsq_prescale #(
        .DIV (CLK_DIV)
    ) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    dsq_phase_fsm #(
        .SI_COUNTS    (SI_COUNTS),
        .REF_MAX      (REF_MAX),
        .CYCLE_COUNTS (CYCLE_COUNTS)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .cmp_i    (cmp_i),
        .phase    (phase),
        .pol      (pol),
        .clr_cnt  (clr_cnt),
        .adv_cnt  (adv_cnt),
        .done     (done),
        .done_ovr (done_ovr)
    );

    dsq_bcd_chain #(
        .DIGITS (NDIG)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr_cnt),
        .adv    (adv_cnt),
        .q_next (cnt_next)
    );

    // Result capture at the end of de-integration only.
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (done) begin
            held.neg <= pol;
            held.ovr <= done_ovr;
            if (done_ovr) begin
                held.msd <= 1'b1;
                held.hun <= DIG_BLANK;
                held.ten <= DIG_BLANK;
                held.one <= DIG_BLANK;
            end else begin
                held.msd <= |cnt_next[3];
                held.hun <= cnt_next[2];
                held.ten <= cnt_next[1];
                held.one <= cnt_next[0];
            end
        end
    end

    assign shown     = test_all ? lamp_value(held.ovr) : held;

    assign ph_az     = (phase == PH_AZ);
    assign ph_si     = (phase == PH_SI);
    assign ref_pos   = (phase == PH_RI) &&  pol;
    assign ref_neg   = (phase == PH_RI) && !pol;

    assign disp_sign = shown.neg;
    assign disp_msd  = shown.msd;
    assign disp_d2   = shown.hun;
    assign disp_d1   = shown.ten;
    assign disp_d0   = shown.one;
    assign disp_ovr  = shown.ovr;

endmodule

// File: rtl/dsq_sequencer_chk.sv
module dsq_sequencer_chk #(
    parameter int CLK_DIV      = 4,
    parameter int SI_COUNTS    = 1000,
    parameter int CYCLE_COUNTS = 4000
) (
    input logic       clk,
    input logic       rst,
    input logic       test_all,
    input logic       ph_az,
    input logic       ph_si,
    input logic       ref_pos,
    input logic       ref_neg,
    input logic       disp_sign,
    input logic       disp_msd,
    input logic [3:0] disp_d2,
    input logic [3:0] disp_d1,
    input logic [3:0] disp_d0,
    input logic       disp_ovr
);
    localparam int SI_CLKS  = SI_COUNTS * CLK_DIV;
    localparam int CYC_CLKS = CYCLE_COUNTS * CLK_DIV;

    logic ph_ri;
    int   si_clks;
    int   cyc_clks;
    logic seen_si;
    logic si_q;

    assign ph_ri = ref_pos | ref_neg;

    always_ff @(posedge clk) begin
        if (rst) begin
            si_clks  <= 0;
            cyc_clks <= 0;
            seen_si  <= 1'b0;
            si_q     <= 1'b0;
        end else begin
            si_q    <= ph_si;
            si_clks <= ph_si ? si_clks + 1 : 0;
            if (ph_si && !si_q) begin
                cyc_clks <= 1;
                seen_si  <= 1'b1;
            end else begin
                cyc_clks <= cyc_clks + 1;
            end
        end
    end

    // R5: exactly one phase select
    p_one_phase_r5: assert property (@(posedge clk) disable iff (rst)
        $countones({ph_az, ph_si, ref_pos, ref_neg}) == 1);

    // R5: phase order
    p_si_after_az_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(ph_si) |-> $past(ph_az));
    p_ri_after_si_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(ph_ri) |-> $past(ph_si));
    p_az_after_ri_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(ph_az) |-> $past(ph_ri));

    // R2: integrate length in clocks
    p_si_len_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(ph_si) |-> (si_clks == SI_CLKS));

    // R4: constant conversion period
    p_cycle_len_r4: assert property (@(posedge clk) disable iff (rst)
        (ph_si && !si_q && seen_si) |-> (cyc_clks == CYC_CLKS));

    // R8: shown result moves only when de-integration ends
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!test_all && $past(!test_all) && !($past(ph_ri) && !ph_ri))
        |-> $stable({disp_sign, disp_msd, disp_d2, disp_d1, disp_d0, disp_ovr}));

    // R7: overrange pattern
    p_ovr_pattern_r7: assert property (@(posedge clk) disable iff (rst)
        (disp_ovr && !test_all)
        |-> (disp_msd && disp_d2 == 4'hF && disp_d1 == 4'hF && disp_d0 == 4'hF));

    // R9: lamp test
    p_lamp_r9: assert property (@(posedge clk) disable iff (rst)
        test_all |-> (disp_sign && disp_msd && disp_d2 == 4'h8
                      && disp_d1 == 4'h8 && disp_d0 == 4'h8));

    // R11: in-range digits are decimal
    p_bcd_r11: assert property (@(posedge clk) disable iff (rst)
        (!disp_ovr && !test_all) |-> (disp_d2 <= 4'd9 && disp_d1 <= 4'd9 && disp_d0 <= 4'd9));

endmodule

bind dsq_sequencer dsq_sequencer_chk #(
    .CLK_DIV      (CLK_DIV),
    .SI_COUNTS    (SI_COUNTS),
    .CYCLE_COUNTS (CYCLE_COUNTS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .test_all  (test_all),
    .ph_az     (ph_az),
    .ph_si     (ph_si),
    .ref_pos   (ref_pos),
    .ref_neg   (ref_neg),
    .disp_sign (disp_sign),
    .disp_msd  (disp_msd),
    .disp_d2   (disp_d2),
    .disp_d1   (disp_d1),
    .disp_d0   (disp_d0),
    .disp_ovr  (disp_ovr)
);

// File: tb/dsq_sequencer_bench.sv
module dsq_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV   = 4;
    localparam int SI    = 250;
    localparam int REF   = 1200;
    localparam int CYC   = 1700;
    localparam int AZMIN = CYC - SI - REF;

    typedef struct packed {
        logic        pol;
        logic        ovr;
        logic [11:0] n;
        logic [15:0] disp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 12'd1,    16'h0001},
        '{1'b1, 1'b0, 12'd9,    16'h0009},
        '{1'b0, 1'b0, 12'd10,   16'h0010},
        '{1'b1, 1'b0, 12'd99,   16'h0099},
        '{1'b0, 1'b0, 12'd100,  16'h0100},
        '{1'b1, 1'b0, 12'd457,  16'h0457},
        '{1'b0, 1'b0, 12'd999,  16'h0999},
        '{1'b1, 1'b0, 12'd1000, 16'h1000},
        '{1'b0, 1'b0, 12'd1101, 16'h1101},
        '{1'b1, 1'b0, 12'd1199, 16'h1199},
        '{1'b1, 1'b1, 12'd1200, 16'h1FFF},
        '{1'b0, 1'b0, 12'd58,   16'h0058}
    };

    logic       clk;
    logic       rst;
    logic       cmp_i;
    logic       test_all;
    logic       ph_az;
    logic       ph_si;
    logic       ref_pos;
    logic       ref_neg;
    logic       disp_sign;
    logic       disp_msd;
    logic [3:0] disp_d2;
    logic [3:0] disp_d1;
    logic [3:0] disp_d0;
    logic       disp_ovr;

    int checks;
    int fails;

    dsq_sequencer #(
        .CLK_DIV      (DIV),
        .SI_COUNTS    (SI),
        .REF_MAX      (REF),
        .CYCLE_COUNTS (CYC)
    ) u_dsq_sequencer (
        .clk       (clk),
        .rst       (rst),
        .cmp_i     (cmp_i),
        .test_all  (test_all),
        .ph_az     (ph_az),
        .ph_si     (ph_si),
        .ref_pos   (ref_pos),
        .ref_neg   (ref_neg),
        .disp_sign (disp_sign),
        .disp_msd  (disp_msd),
        .disp_d2   (disp_d2),
        .disp_d1   (disp_d1),
        .disp_d0   (disp_d0),
        .disp_ovr  (disp_ovr)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int shown();
        return int'({3'b000, disp_msd, disp_d2, disp_d1, disp_d0});
    endfunction

    // Count negedges while the given phase output stays high.
    task automatic hold_len(input int which, output int len);
        len = 0;
        while ((which == 0) ? ph_az : (which == 1) ? ph_si : (ref_pos | ref_neg)) begin
            len++;
            @(negedge clk);
        end
    endtask

    // De-integrate, tripping the comparator so the n-th count sees the crossing.
    task automatic run_ri(input logic pol, input int n, input logic trip, output int len);
        len = 0;
        while (ref_pos | ref_neg) begin
            len++;
            if (trip && len == DIV * (n - 1) + 1) cmp_i = ~pol;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int len;
        int exp_az;
        int prev_disp;
        logic prev_ovr;
        checks   = 0;
        fails    = 0;
        rst      = 1'b1;
        cmp_i    = 1'b0;
        test_all = 1'b0;
        repeat (3) @(negedge clk);

        // R10: reset state
        chk("R10 reset phase", int'({ph_az, ph_si, ref_pos, ref_neg}), 8);
        chk("R10 reset display", shown(), 0);
        chk("R10 reset sign/ovr", int'({disp_sign, disp_ovr}), 0);
        rst = 1'b0;

        exp_az    = AZMIN;
        prev_disp = 0;
        prev_ovr  = 1'b0;
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VEC[i];
            cmp_i = v.pol;
            hold_len(0, len);
            if (i == 0) chk("R10 first zeroing", len, DIV * exp_az);
            else        chk("R4 zeroing refill", len, DIV * exp_az);
            hold_len(1, len);
            chk("R1 R2 integrate length", len, DIV * SI);
            // R5/R6: reference sign chosen from sampled polarity
            chk("R5 R6 reference select", int'({ref_pos, ref_neg}), v.pol ? 2 : 1);
            chk("R8 held during conversion", shown(), prev_disp);
            run_ri(v.pol, int'(v.n), !v.ovr, len);
            if (v.ovr) chk("R7 limit length", len, DIV * REF);
            else       chk("R3 deintegrate length", len, DIV * int'(v.n));
            chk("R11 R7 digits", shown(), int'(v.disp));
            chk("R6 sign", int'(disp_sign), int'(v.pol));
            chk("R7 overrange flag", int'(disp_ovr), int'(v.ovr));
            exp_az    = CYC - SI - int'(v.n);
            prev_disp = int'(v.disp);
            prev_ovr  = v.ovr;
        end

        // R9: lamp test held through a whole conversion of 321 counts, negative input
        cmp_i = 1'b1;
        hold_len(0, len);
        chk("R4 zeroing refill", len, DIV * exp_az);
        test_all = 1'b1;
        #1;
        chk("R9 lamp digits", shown(), 16'h1888);
        chk("R9 lamp sign", int'(disp_sign), 1);
        chk("R9 ovr passes", int'(disp_ovr), int'(prev_ovr));
        hold_len(1, len);
        chk("R9 integrate timing", len, DIV * SI);
        run_ri(1'b1, 321, 1'b1, len);
        chk("R9 deintegrate timing", len, DIV * 321);
        chk("R9 lamp after capture", shown(), 16'h1888);
        test_all = 1'b0;
        #1;
        chk("R9 captured under lamp", shown(), 16'h0321);
        chk("R9 captured sign", int'(disp_sign), 1);

        // R10: reset in the middle of de-integration
        cmp_i = 1'b0;
        while (!(ref_pos | ref_neg)) @(negedge clk);
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R10 midrun phase", int'({ph_az, ph_si, ref_pos, ref_neg}), 8);
        chk("R10 midrun display", shown(), 0);
        chk("R10 midrun sign/ovr", int'({disp_sign, disp_ovr}), 0);
        rst = 1'b0;
        hold_len(0, len);
        chk("R10 zeroing after reset", len, DIV * AZMIN);
        hold_len(1, len);
        chk("R2 integrate after reset", len, DIV * SI);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule